// File: doc/BRIEF.md
# Multiply-Accumulate Overflow and Saturation Unit

This block is the arithmetic back end of a multiply-accumulate engine. It keeps four accumulators and one status word. On each strobed command it either forms a product of two 32-bit operands and adds it into one accumulator, or saturates an accumulator, or re-evaluates the condition flags, or copies one accumulator into another, or produces a clamped 32-bit readout, or loads the mode bits. The product can be signed, unsigned or fractional. Overflow is detected on the product and again on the accumulator. Per-accumulator sticky overflow bits record which accumulators have saturated.

Each accumulator is held as a 64-bit word. Its architectural value is 48 bits wide; the 16 bits above it are guard bits that carry a transient overflow until a saturate command folds it back. Commands are encoded on `op_i`: 0 idle, 1 signed multiply-add, 2 unsigned multiply-add, 3 fractional multiply-add, 4 signed saturate, 5 unsigned saturate, 6 fractional saturate, 7 flag update, 8 move, 9 signed readout, 10 unsigned readout, 11 mode load. Codes 12 to 15 are reserved. `dst_i` selects the target accumulator and `src_i` selects the source of a move.

Status word layout: bit 0 extension overflow, bit 1 negative, bit 2 zero, bit 3 overflow, bit 4 fractional-integer mode, bit 5 rounding enable, bit 6 signed-upper mode, bit 7 overflow-saturate mode, bits 11:8 sticky overflow of accumulators 3..0 (bit 8 for accumulator 0).

Top module: `mac_sat_unit`

## Requirements
- R1: After reset every accumulator, the status word and the readout are zero.
- R2: Signed multiply-add (op 1) forms the 64-bit signed product. The product overflows when it differs from its own sign extension from bit 39. Overflow sets bit 3. With bit 7 set, an overflowing product is replaced by +2^50, or by -2^50 if it is negative. The product is then added into the accumulator `dst_i`, wrapping at 64 bits.
- R3: Unsigned multiply-add (op 2) sets bit 3 when any product bit from 40 upward is one. Such a product becomes 2^50 with bit 7 set, and otherwise keeps only its low 40 bits. The result is then added.
- R4: Fractional multiply-add (op 3) uses the signed product. With bit 5 set, the low 24 bits are rounded off: the value rounds up above half, stays put below half, and at exactly half it goes to the even multiple of 2^24. With bit 5 clear, the product is added unrounded.
- R5: Signed saturate (op 4) sets bit 3 when the accumulator differs from its sign extension from bit 47. While bit 3 is set afterwards, it sets the sticky bit of that accumulator. With bit 7 set, the accumulator becomes 0x7fffffff or 0xffffffff80000000, chosen by the sign of the 48-bit value. Otherwise it becomes that sign-extended value.
- R6: Unsigned saturate (op 5) sets bit 3 when any of bits 63..48 is one. While bit 3 is set, it sets the sticky bit. Under bit 7, the value becomes 0 if it exceeds 2^53 and 2^48-1 otherwise. Without bit 7 it is masked to 48 bits. While bit 3 is clear the value is unchanged.
- R7: Fractional saturate (op 6) detects overflow and sets the sticky bit as R5 does. With bit 7 and bit 3 set, the value clamps to 0x7fffffffffff, XORed with the sign-extended sign.
- R8: Flag update (op 7) clears bits 0..2. It then sets bit 2 when the accumulator is zero, or else bit 1 when its bit 47 is one. It sets bit 3 when that accumulator's sticky bit is set.
- R9: In flag update, bit 0 is set under the following rules. With bit 4 set, it is set when bits 63..40 are neither all zero nor all one. Else, with bit 6 set, the same test applies to bits 63..32. Else it is set when any of bits 63..32 is one.
- R10: Signed readout (op 9) loads `rdout_o` with the low 32 bits when the accumulator fits a signed 32-bit value, and otherwise with 0x7fffffff (positive) or 0x80000000 (negative). Unsigned readout (op 10) gives 0xffffffff when any of bits 63..32 is one, and the low 32 bits otherwise.
- R11: Move (op 8) copies accumulator `src_i` into `dst_i`, and copies the sticky bit of the source into the sticky bit of the destination.
- R12: Mode load (op 11) writes `opa_i[0]`, `[1]`, `[2]` and `[3]` into status bits 4, 5, 6 and 7, and clears every flag and sticky bit.
- R13: Every command takes effect on the first rising edge where `valid_i` is high. Without `valid_i`, or with a reserved code, nothing changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Command strobe |
| op_i | input | 4 | Command code |
| opa_i | input | 32 | First operand, or mode bits for op 11 |
| opb_i | input | 32 | Second operand |
| dst_i | input | 2 | Target accumulator |
| src_i | input | 2 | Source accumulator for a move |
| acc_o | output | 256 | All accumulators, accumulator 0 in bits 63:0 |
| status_o | output | 12 | Status word |
| rdout_o | output | 32 | Last 32-bit readout |

## Verification
All results are registered, so every command shows its effect on the accumulators, the status word and the readout one rising edge after it is strobed. The bench drives each command on a falling edge and drops the strobe on the next falling edge. At that same falling edge, after the single rising edge, it compares all three outputs against its model. The idle half-cycle that this leaves between commands also exercises the hold behaviour, and a run of plain idle cycles confirms that nothing drifts.

// File: rtl/mac_sat_pkg.sv
package mac_sat_pkg;

    localparam int ACC_W       = 64;
    localparam int OPD_W       = 32;
    localparam int NUM_ACC     = 4;
    localparam int IDX_W       = $clog2(NUM_ACC);
    localparam int FIELD_W     = 48;
    localparam int SPROD_W     = 40;
    localparam int FRAC_SHIFT  = 24;
    localparam int FORCE_BIT   = 50;
    localparam int ULIM_BIT    = 53;
    localparam int EV_FI_LO    = 40;
    localparam int EV_SU_LO    = 32;
    localparam int FLAG_N      = 4;
    localparam int MODE_N      = 4;
    localparam int STAT_W      = FLAG_N + MODE_N + NUM_ACC;

    typedef logic [ACC_W-1:0] acc_word_t;

    typedef enum logic [3:0] {
        OP_NOP     = 4'd0,
        OP_MULS    = 4'd1,
        OP_MULU    = 4'd2,
        OP_MULF    = 4'd3,
        OP_SATS    = 4'd4,
        OP_SATU    = 4'd5,
        OP_SATF    = 4'd6,
        OP_FLAGS   = 4'd7,
        OP_MOVE    = 4'd8,
        OP_RDS     = 4'd9,
        OP_RDU     = 4'd10,
        OP_SETMODE = 4'd11
    } mac_op_e;

    typedef enum logic [1:0] {
        KIND_S = 2'd0,
        KIND_U = 2'd1,
        KIND_F = 2'd2
    } mac_kind_e;

    typedef struct packed {
        logic [NUM_ACC-1:0] pav;
        logic               omc;
        logic               su;
        logic               rt;
        logic               fi;
        logic               v;
        logic               z;
        logic               n;
        logic               ev;
    } mac_status_t;

    typedef struct packed {
        acc_word_t [NUM_ACC-1:0] acc;
        mac_status_t             st;
        logic [OPD_W-1:0]        rd;
    } mac_state_t;

    function automatic acc_word_t sext_from(input acc_word_t v, input int unsigned bits);
        acc_word_t sh;
        sh = v << (ACC_W - bits);
        return acc_word_t'($signed(sh) >>> (ACC_W - bits));
    endfunction

endpackage

// File: rtl/mac_product.sv
module mac_product
    import mac_sat_pkg::*;
(
    input  logic [OPD_W-1:0] a_i,
    input  logic [OPD_W-1:0] b_i,
    input  mac_kind_e        kind_i,
    input  logic             omc_i,
    input  logic             rt_i,
    output acc_word_t        prod_o,
    output logic             ovf_o
);
    localparam logic [FRAC_SHIFT-1:0] HALF      = {1'b1, {(FRAC_SHIFT-1){1'b0}}};
    localparam acc_word_t             FORCE_MAG = acc_word_t'(1) << FORCE_BIT;
    localparam acc_word_t             LOW40     = (acc_word_t'(1) << SPROD_W) - 1;

    acc_word_t             raw_s;
    acc_word_t             raw_u;
    acc_word_t             quo;
    acc_word_t             rounded;
    logic [FRAC_SHIFT-1:0] rem;

    always_comb begin
        raw_s   = {{(ACC_W-OPD_W){a_i[OPD_W-1]}}, a_i} * {{(ACC_W-OPD_W){b_i[OPD_W-1]}}, b_i};
        raw_u   = {{(ACC_W-OPD_W){1'b0}}, a_i} * {{(ACC_W-OPD_W){1'b0}}, b_i};
        rem     = raw_s[FRAC_SHIFT-1:0];
        quo     = acc_word_t'($signed(raw_s) >>> FRAC_SHIFT);
        if (rem > HALF) begin
            quo = quo + acc_word_t'(1);
        end else if (rem == HALF) begin
            quo = quo + acc_word_t'(quo[0]);
        end
        rounded = quo << FRAC_SHIFT;

        prod_o = raw_s;
        ovf_o  = 1'b0;
        case (kind_i)
            KIND_S: begin
                ovf_o = (raw_s != sext_from(raw_s, SPROD_W));
                if (ovf_o && omc_i) begin
                    prod_o = raw_s[ACC_W-1] ? (acc_word_t'(0) - FORCE_MAG) : FORCE_MAG;
                end
            end
            KIND_U: begin
                ovf_o  = |raw_u[ACC_W-1:SPROD_W];
                prod_o = raw_u;
                if (ovf_o) begin
                    prod_o = omc_i ? FORCE_MAG : (raw_u & LOW40);
                end
            end
            default: begin
                prod_o = rt_i ? rounded : raw_s;
            end
        endcase
    end
endmodule

// File: rtl/mac_saturate.sv
module mac_saturate
    import mac_sat_pkg::*;
(
    input  acc_word_t val_i,
    input  mac_kind_e kind_i,
    input  logic      v_i,
    input  logic      omc_i,
    output acc_word_t val_o,
    output logic      v_o
);
    localparam acc_word_t MAX32S = (acc_word_t'(1) << (OPD_W-1)) - 1;
    localparam acc_word_t MAX48S = (acc_word_t'(1) << (FIELD_W-1)) - 1;
    localparam acc_word_t MAX48U = (acc_word_t'(1) << FIELD_W) - 1;
    localparam acc_word_t ULIMIT = acc_word_t'(1) << ULIM_BIT;

    acc_word_t sx;

    always_comb begin
        sx    = sext_from(val_i, FIELD_W);
        val_o = val_i;
        v_o   = v_i;
        case (kind_i)
            KIND_U: begin
                v_o = v_i | (|val_i[ACC_W-1:FIELD_W]);
                if (v_o) begin
                    if (omc_i) begin
                        val_o = (val_i > ULIMIT) ? '0 : MAX48U;
                    end else begin
                        val_o = val_i & MAX48U;
                    end
                end
            end
            KIND_F: begin
                v_o   = v_i | (val_i != sx);
                val_o = sx;
                if (v_o && omc_i) begin
                    val_o = {ACC_W{sx[ACC_W-1]}} ^ MAX48S;
                end
            end
            default: begin
                v_o   = v_i | (val_i != sx);
                val_o = sx;
                if (v_o && omc_i) begin
                    val_o = {ACC_W{sx[ACC_W-1]}} ^ MAX32S;
                end
            end
        endcase
    end
endmodule

// File: rtl/mac_flag_eval.sv
module mac_flag_eval
    import mac_sat_pkg::*;
(
    input  acc_word_t val_i,
    input  logic      fi_i,
    input  logic      su_i,
    output logic      z_o,
    output logic      n_o,
    output logic      ev_o
);
    always_comb begin
        z_o = (val_i == '0);
        n_o = !z_o && val_i[FIELD_W-1];
        if (fi_i) begin
            ev_o = !((&val_i[ACC_W-1:EV_FI_LO]) || !(|val_i[ACC_W-1:EV_FI_LO]));
        end else if (su_i) begin
            ev_o = !((&val_i[ACC_W-1:EV_SU_LO]) || !(|val_i[ACC_W-1:EV_SU_LO]));
        end else begin
            ev_o = |val_i[ACC_W-1:EV_SU_LO];
        end
    end
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
    import mac_sat_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid_i,
    input  logic [3:0]               op_i,
    input  logic [OPD_W-1:0]         opa_i,
    input  logic [OPD_W-1:0]         opb_i,
    input  logic [IDX_W-1:0]         dst_i,
    input  logic [IDX_W-1:0]         src_i,
    output logic [NUM_ACC*ACC_W-1:0] acc_o,
    output logic [STAT_W-1:0]        status_o,
    output logic [OPD_W-1:0]         rdout_o
);
    mac_state_t state_d, state_q;
    mac_op_e    op;
    mac_kind_e  mul_kind, sat_kind;
    acc_word_t  sel_acc, src_acc;
    acc_word_t  prod, sat_val;
    logic       prod_ovf, sat_v;
    logic       fz, fn, fev;

    assign op      = mac_op_e'(op_i);
    assign sel_acc = state_q.acc[dst_i];
    assign src_acc = state_q.acc[src_i];

    always_comb begin
        case (op)
            OP_MULU: mul_kind = KIND_U;
            OP_MULF: mul_kind = KIND_F;
            default: mul_kind = KIND_S;
        endcase
        case (op)
            OP_SATU: sat_kind = KIND_U;
            OP_SATF: sat_kind = KIND_F;
            default: sat_kind = KIND_S;
        endcase
    end

    mac_product u_prod (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .kind_i (mul_kind),
        .omc_i  (state_q.st.omc),
        .rt_i   (state_q.st.rt),
        .prod_o (prod),
        .ovf_o  (prod_ovf)
    );

    mac_saturate u_sat (
        .val_i  (sel_acc),
        .kind_i (sat_kind),
        .v_i    (state_q.st.v),
        .omc_i  (state_q.st.omc),
        .val_o  (sat_val),
        .v_o    (sat_v)
    );

    mac_flag_eval u_flags (
        .val_i (sel_acc),
        .fi_i  (state_q.st.fi),
        .su_i  (state_q.st.su),
        .z_o   (fz),
        .n_o   (fn),
        .ev_o  (fev)
    );

    always_comb begin
        state_d = state_q;
        if (valid_i) begin
            case (op)
                OP_MULS, OP_MULU, OP_MULF: begin
                    state_d.acc[dst_i] = sel_acc + prod;
                    state_d.st.v       = state_q.st.v | prod_ovf;
                end
                OP_SATS, OP_SATU, OP_SATF: begin
                    state_d.acc[dst_i] = sat_val;
                    state_d.st.v       = sat_v;
                    if (sat_v) begin
                        state_d.st.pav[dst_i] = 1'b1;
                    end
                end
                OP_FLAGS: begin
                    state_d.st.z  = fz;
                    state_d.st.n  = fn;
                    state_d.st.ev = fev;
                    state_d.st.v  = state_q.st.v | state_q.st.pav[dst_i];
                end
                OP_MOVE: begin
                    state_d.acc[dst_i]    = src_acc;
                    state_d.st.pav[dst_i] = state_q.st.pav[src_i];
                end
                OP_RDS: begin
                    if (sel_acc == sext_from(sel_acc, OPD_W)) begin
                        state_d.rd = sel_acc[OPD_W-1:0];
                    end else begin
                        state_d.rd = {sel_acc[ACC_W-1], {(OPD_W-1){!sel_acc[ACC_W-1]}}};
                    end
                end
                OP_RDU: begin
                    state_d.rd = (|sel_acc[ACC_W-1:OPD_W]) ? '1 : sel_acc[OPD_W-1:0];
                end
                OP_SETMODE: begin
                    state_d.st     = '0;
                    state_d.st.fi  = opa_i[0];
                    state_d.st.rt  = opa_i[1];
                    state_d.st.su  = opa_i[2];
                    state_d.st.omc = opa_i[3];
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign acc_o    = state_q.acc;
    assign status_o = state_q.st;
    assign rdout_o  = state_q.rd;
endmodule

// File: rtl/mac_sat_unit_chk.sv
module mac_sat_unit_chk
    import mac_sat_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     valid_i,
    input logic [3:0]               op_i,
    input logic [IDX_W-1:0]         dst_i,
    input logic [NUM_ACC*ACC_W-1:0] acc_o,
    input logic [STAT_W-1:0]        status_o,
    input logic [OPD_W-1:0]         rdout_o
);
    localparam int PAV_LO = FLAG_N + MODE_N;

    acc_word_t sel_w;
    logic      is_setmode, is_move;
    assign sel_w      = acc_o[dst_i*ACC_W +: ACC_W];
    assign is_setmode = valid_i && (op_i == OP_SETMODE);
    assign is_move    = valid_i && (op_i == OP_MOVE);

    // R12: mode load leaves no flag and no sticky bit behind
    a_r12_setmode_clears: assert property (@(posedge clk) disable iff (!rst_n)
        is_setmode |=> (status_o[FLAG_N-1:0] == '0) && (status_o[STAT_W-1:PAV_LO] == '0));

    // R12: mode bits change only on a mode load
    a_r12_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !is_setmode |=> $stable(status_o[PAV_LO-1:FLAG_N]));

    // R13: without a strobe all outputs hold
    a_r13_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(acc_o) && $stable(status_o) && $stable(rdout_o));

    // R5: sticky overflow bits only rise, except on mode load or move
    a_r5_pav_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_setmode || is_move) |=>
            ((status_o[STAT_W-1:PAV_LO] & $past(status_o[STAT_W-1:PAV_LO])) == $past(status_o[STAT_W-1:PAV_LO])));

    // R2: overflow flag is sticky until a mode load
    a_r2_v_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_setmode && status_o[3]) |=> status_o[3]);

    // R8: zero and negative never both set after a flag update
    a_r8_zn_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == OP_FLAGS) |=> !(status_o[2] && status_o[1]));

    // R10: unsigned readout clamps a wide value to all ones
    a_r10_unsigned_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == OP_RDU && (|sel_w[ACC_W-1:OPD_W])) |=> (rdout_o == '1));
endmodule

bind mac_sat_unit mac_sat_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (valid_i),
    .op_i     (op_i),
    .dst_i    (dst_i),
    .acc_o    (acc_o),
    .status_o (status_o),
    .rdout_o  (rdout_o)
);

// File: tb/mac_sat_unit_test.sv
module mac_sat_unit_test;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid_i = 1'b0;
    logic [3:0]   op_i = '0;
    logic [31:0]  opa_i = '0;
    logic [31:0]  opb_i = '0;
    logic [1:0]   dst_i = '0;
    logic [1:0]   src_i = '0;
    logic [255:0] acc_o;
    logic [11:0]  status_o;
    logic [31:0]  rdout_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [63:0] m_acc [4];
    logic        m_v, m_z, m_n, m_ev, m_fi, m_rt, m_su, m_omc;
    logic [3:0]  m_pav;
    logic [31:0] m_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_sat_unit uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (valid_i),
        .op_i     (op_i),
        .opa_i    (opa_i),
        .opb_i    (opb_i),
        .dst_i    (dst_i),
        .src_i    (src_i),
        .acc_o    (acc_o),
        .status_o (status_o),
        .rdout_o  (rdout_o)
    );

    function automatic logic [11:0] m_status();
        return {m_pav, m_omc, m_su, m_rt, m_fi, m_v, m_z, m_n, m_ev};
    endfunction

    function automatic string req_of(input int op);
        case (op)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            6: return "R7";
            7: return "R8/R9";
            8: return "R11";
            9, 10: return "R10";
            11: return "R12";
            default: return "R13";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) m_acc[i] = '0;
        {m_v, m_z, m_n, m_ev, m_fi, m_rt, m_su, m_omc} = '0;
        m_pav = '0;
        m_rd  = '0;
    endtask

    task automatic model_apply(input int op, input logic [31:0] a, input logic [31:0] b, input int d, input int s);
        longint p, q, r, t;
        logic [63:0] u;
        case (op)
            1: begin
                p = longint'($signed(a)) * longint'($signed(b));
                if (p != ((p <<< 24) >>> 24)) begin
                    m_v = 1'b1;
                    if (m_omc) p = (p < 0) ? -(64'sd1 <<< 50) : (64'sd1 <<< 50);
                end
                m_acc[d] = m_acc[d] + p;
            end
            2: begin
                u = {32'b0, a} * {32'b0, b};
                if ((u >> 40) != 0) begin
                    m_v = 1'b1;
                    u = m_omc ? (64'd1 << 50) : (u & 64'hff_ffff_ffff);
                end
                m_acc[d] = m_acc[d] + u;
            end
            3: begin
                p = longint'($signed(a)) * longint'($signed(b));
                if (m_rt) begin
                    q = p >>> 24;
                    r = p & 64'hff_ffff;
                    if (r > 64'h80_0000) q = q + 1;
                    else if (r == 64'h80_0000 && q[0]) q = q + 1;
                    p = q <<< 24;
                end
                m_acc[d] = m_acc[d] + p;
            end
            4, 6: begin
                t = m_acc[d];
                r = (t <<< 16) >>> 16;
                if (r != t) m_v = 1'b1;
                if (m_v) begin
                    m_pav[d] = 1'b1;
                    if (m_omc) begin
                        if (op == 4) r = (r < 0) ? 64'hffff_ffff_8000_0000 : 64'h7fff_ffff;
                        else         r = (r < 0) ? 64'hffff_8000_0000_0000 : 64'h7fff_ffff_ffff;
                    end
                end
                m_acc[d] = r;
            end
            5: begin
                u = m_acc[d];
                if (u[63:48] != 0) m_v = 1'b1;
                if (m_v) begin
                    m_pav[d] = 1'b1;
                    if (m_omc) u = (u > (64'd1 << 53)) ? 64'd0 : 64'h0000_ffff_ffff_ffff;
                    else       u = u & 64'h0000_ffff_ffff_ffff;
                end
                m_acc[d] = u;
            end
            7: begin
                t = m_acc[d];
                m_z = 1'b0; m_n = 1'b0; m_ev = 1'b0;
                if (t == 0) m_z = 1'b1;
                else if (t[47]) m_n = 1'b1;
                if (m_pav[d]) m_v = 1'b1;
                if (m_fi)      m_ev = ((t >>> 40) != 0) && ((t >>> 40) != -1);
                else if (m_su) m_ev = ((t >>> 32) != 0) && ((t >>> 32) != -1);
                else           m_ev = (m_acc[d] >> 32) != 0;
            end
            8: begin
                m_acc[d] = m_acc[s];
                m_pav[d] = m_pav[s];
            end
            9: begin
                t = m_acc[d];
                if (t == longint'($signed(t[31:0]))) m_rd = t[31:0];
                else m_rd = (t < 0) ? 32'h8000_0000 : 32'h7fff_ffff;
            end
            10: begin
                u = m_acc[d];
                m_rd = (u[63:32] != 0) ? 32'hffff_ffff : u[31:0];
            end
            11: begin
                {m_v, m_z, m_n, m_ev} = '0;
                m_pav = '0;
                m_fi = a[0]; m_rt = a[1]; m_su = a[2]; m_omc = a[3];
            end
            default: begin
            end
        endcase
    endtask

    task automatic compare_all(input string req);
        chk(req, "acc", acc_o, {m_acc[3], m_acc[2], m_acc[1], m_acc[0]});
        chk(req, "status", {244'b0, status_o}, {244'b0, m_status()});
        chk(req, "rdout", {224'b0, rdout_o}, {224'b0, m_rd});
    endtask

    task automatic do_op(input int op, input logic [31:0] a, input logic [31:0] b, input int d, input int s);
        @(negedge clk);
        op_i = op[3:0]; opa_i = a; opb_i = b; dst_i = d[1:0]; src_i = s[1:0];
        valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        model_apply(op, a, b, d, s);
        compare_all(req_of(op));
    endtask

    function automatic logic [255:0] accw(input int d);
        return {192'b0, acc_o[d*64 +: 64]};
    endfunction

    function automatic logic [31:0] pick_operand();
        case ($urandom_range(0, 5))
            0: return 32'h7fff_ffff;
            1: return 32'h8000_0000;
            2: return 32'hffff_ffff;
            3: return 32'(($urandom_range(0, 3)) << 22);
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "acc after reset", acc_o, '0);
        chk("R1", "status after reset", {244'b0, status_o}, '0);
        chk("R1", "rdout after reset", {224'b0, rdout_o}, '0);
        rst_n = 1'b1;

        // R2: signed overflow without and with forcing
        do_op(11, 32'h0, 0, 0, 0);
        do_op(1, 32'h7fff_ffff, 32'h7fff_ffff, 0, 0);
        chk("R2", "acc0 unforced", accw(0), 256'h3fff_ffff_0000_0001);
        chk("R2", "V set", {255'b0, status_o[3]}, 256'd1);
        do_op(11, 32'h8, 0, 0, 0);
        do_op(1, 32'h7fff_ffff, 32'h7fff_ffff, 1, 0);
        chk("R2", "acc1 forced", accw(1), 256'h0004_0000_0000_0000);

        // R5: signed saturate to 32-bit limit
        do_op(4, 0, 0, 1, 0);
        chk("R5", "acc1 clamp", accw(1), 256'h7fff_ffff);
        chk("R5", "PAV1", {255'b0, status_o[9]}, 256'd1);

        // R3: unsigned product masking
        do_op(11, 32'h0, 0, 0, 0);
        do_op(2, 32'hffff_ffff, 32'hffff_ffff, 2, 0);
        chk("R3", "acc2 masked", accw(2), 256'hfe_0000_0001);

        // R4: rounding
        do_op(11, 32'h2, 0, 0, 0);
        do_op(3, 32'h0080_0000, 32'd3, 3, 0);
        chk("R4", "half rounds to even up", accw(3), 256'h200_0000);
        do_op(3, 32'h0080_0000, 32'd1, 3, 0);
        chk("R4", "half stays even", accw(3), 256'h200_0000);
        do_op(3, 32'h00c0_0000, 32'd1, 3, 0);
        chk("R4", "above half", accw(3), 256'h300_0000);
        do_op(11, 32'h0, 0, 0, 0);
        do_op(3, 32'h00c0_0000, 32'd1, 3, 0);
        chk("R4", "no rounding", accw(3), 256'h3c0_0000);

        // R6: unsigned saturate
        do_op(11, 32'h8, 0, 0, 0);
        do_op(2, 32'hffff_ffff, 32'hffff_ffff, 0, 0);
        do_op(5, 0, 0, 0, 0);
        chk("R6", "above 2^53 clamps to zero", accw(0), '0);
        do_op(5, 0, 0, 1, 0);
        chk("R6", "clamp to 2^48-1", accw(1), 256'hffff_ffff_ffff);

        // R7: fractional saturate
        do_op(6, 0, 0, 2, 0);
        chk("R7", "frac clamp", accw(2), 256'h7fff_ffff_ffff);

        // R8, R9: flags
        do_op(11, 32'h0, 0, 0, 0);
        do_op(7, 0, 0, 0, 0);
        chk("R8", "zero flag", {244'b0, status_o}, 256'h004);
        do_op(1, 32'hffff_ffff, 32'd1, 0, 0);
        do_op(7, 0, 0, 0, 0);
        chk("R9", "N and EV plain mode", {244'b0, status_o}, 256'h003);
        do_op(11, 32'h4, 0, 0, 0);
        do_op(7, 0, 0, 0, 0);
        chk("R9", "SU mode no EV", {244'b0, status_o}, 256'h042);
        do_op(11, 32'h1, 0, 0, 0);
        do_op(7, 0, 0, 2, 0);
        chk("R9", "FI mode EV", {244'b0, status_o}, 256'h011);

        // R10: readouts
        do_op(9, 0, 0, 0, 0);
        chk("R10", "signed fits", {224'b0, rdout_o}, 256'hffff_ffff);
        do_op(9, 0, 0, 2, 0);
        chk("R10", "signed positive clamp", {224'b0, rdout_o}, 256'h7fff_ffff);
        do_op(10, 0, 0, 2, 0);
        chk("R10", "unsigned clamp", {224'b0, rdout_o}, 256'hffff_ffff);
        do_op(10, 0, 0, 3, 0);
        chk("R10", "unsigned fits", {224'b0, rdout_o}, 256'h03c0_0000);
        do_op(1, 32'h8000_0000, 32'h7fff_ffff, 0, 0);
        do_op(9, 0, 0, 0, 0);
        chk("R10", "signed negative clamp", {224'b0, rdout_o}, 256'h8000_0000);

        // R11: move with sticky copy
        do_op(11, 32'h8, 0, 0, 0);
        do_op(1, 32'h7fff_ffff, 32'h7fff_ffff, 1, 0);
        do_op(4, 0, 0, 1, 0);
        do_op(8, 0, 0, 3, 1);
        chk("R11", "acc3 copy", accw(3), 256'hffff_ffff_8000_0000);
        chk("R11", "PAV3 copied", {255'b0, status_o[11]}, 256'd1);
        do_op(8, 0, 0, 1, 0);
        chk("R11", "PAV1 cleared", {255'b0, status_o[9]}, '0);

        // R12: mode load
        do_op(11, 32'hf, 0, 0, 0);
        chk("R12", "mode load", {244'b0, status_o}, 256'h0f0);

        // R13: idle cycles and reserved codes
        repeat (5) @(negedge clk);
        compare_all("R13");
        do_op(13, 32'hffff_ffff, 32'hffff_ffff, 2, 1);

        // random mix
        for (int i = 0; i < 600; i++) begin
            int op;
            op = $urandom_range(0, 12);
            if (op == 11 && $urandom_range(0, 2) != 0) op = 1;
            do_op(op, pick_operand(), pick_operand(), $urandom_range(0, 3), $urandom_range(0, 3));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule